// File: doc/BRIEF.md
# Pulse-Width Modulator with Shift-Scaled Prescale

This block drives one pulse-width modulated output from a free-running 16-bit counter. Software programs it through four 32-bit word registers on a simple single-cycle register bus: a channel enable, a control word, a duty value and a period count. The output is high while the counter is below the duty value. A polarity bit inverts the output, including its idle level when the channel is off.

A 3-bit prescale code picks one of eight nominal moduli. Codes 1 to 6 do not slow the counter. Instead they shift the period and duty values left by a fixed amount inside a 16-bit field, and the bits pushed above bit 15 are lost. Code 7 is the only real divider: the counter advances once every 4096 clocks and the values are used unshifted. New period, duty and prescale settings take effect only when the counter wraps. As a result, every period that reaches the pin is a complete one.

Top module: `pwm_shiftscale`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low.
- R2: Word offsets are 0x00 enable (bit 0), 0x04 control (bits 2:0 prescale code, bit 3 invert), 0x08 duty (bits 15:0) and 0x0C period count (bits 15:0). A read returns the written value, and every unused bit reads as zero.
- R3: A write to any other address is ignored. This covers offsets 0x10 to 0x1F and addresses whose low two bits are not zero. A read of such an address returns zero.
- R4: While enable bit 0 is clear, the counter stays at zero and `pwm_out` equals the invert bit.
- R5: With code 0 the counter runs from 0 to period−1 and then wraps. The raw output is high while the count is below the duty value.
- R6: Codes 1 to 6 shift both period and duty left by 2, 3, 4, 6, 8 and 10 bits respectively. The results are truncated to 16 bits, and the counter still advances every clock.
- R7: Code 7 advances the counter once every 4096 clocks and uses the period and duty values unshifted.
- R8: Control bit 3 set inverts `pwm_out` relative to the raw comparison.
- R9: Period, duty and prescale changes take effect only when the counter wraps. They also take effect at any time while the channel is disabled.
- R10: An effective period of zero keeps the raw output low. An effective duty at or above the effective period keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; data is taken at the clock edge |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Modulated output after polarity |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 5-bit address and a 4096-clock divider for code 7. A period count of 3 under code 7 therefore completes several full periods in a few tens of thousands of clocks, so the real divider is exercised directly and not through a reduced stand-in. The period value 0x4005 and duty value 0x4002 lose bit 14 under every shifting code. This keeps each effective period short and makes the truncation visible at the output.

// File: rtl/pwm_ss_pkg.sv
package pwm_ss_pkg;

    typedef enum logic [1:0] {
        IDX_ENABLE = 2'd0,
        IDX_CTRL   = 2'd1,
        IDX_DUTY   = 2'd2,
        IDX_PERIOD = 2'd3
    } reg_idx_e;

    localparam int CODE_W  = 3;
    localparam int CTRL_W  = 4;
    localparam int INV_BIT = 3;
    localparam logic [CODE_W-1:0] CODE_DIV = 3'd7;

    // Left shift applied to period/duty for each prescale code
    function automatic int unsigned code_shift(input logic [CODE_W-1:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_ss_regs.sv
module pwm_ss_regs
    import pwm_ss_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CNT_W-1:0]  duty,
    output logic [CNT_W-1:0]  period
);

    typedef struct packed {
        logic              en;
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  duty;
        logic [CNT_W-1:0]  period;
    } regs_t;

    regs_t    st_d, st_q;
    logic     hit;
    reg_idx_e idx;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    assign hit = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
    assign idx = reg_idx_e'(addr[3:2]);

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            case (idx)
                IDX_ENABLE: st_d.en     = wdata[0];
                IDX_CTRL:   st_d.ctrl   = wdata[CTRL_W-1:0];
                IDX_DUTY:   st_d.duty   = wdata[CNT_W-1:0];
                IDX_PERIOD: st_d.period = wdata[CNT_W-1:0];
                default:    st_d        = st_q;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (idx)
                IDX_ENABLE: rdata[0]          = st_q.en;
                IDX_CTRL:   rdata[CTRL_W-1:0] = st_q.ctrl;
                IDX_DUTY:   rdata[CNT_W-1:0]  = st_q.duty;
                IDX_PERIOD: rdata[CNT_W-1:0]  = st_q.period;
                default:    rdata             = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign ctrl   = st_q.ctrl;
    assign duty   = st_q.duty;
    assign period = st_q.period;

endmodule

// File: rtl/pwm_ss_tick.sv
module pwm_ss_tick #(
    parameter int DIV_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow,
    output logic tick
);

    typedef struct packed {
        logic [DIV_LOG2-1:0] div;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en || !slow) st_d.div = '0;
        else              st_d.div = st_q.div + 1'b1;
    end

    assign tick = !slow || (st_q.div == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_ss_core.sv
module pwm_ss_core
    import pwm_ss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CNT_W-1:0]  duty,
    input  logic [CNT_W-1:0]  period,
    output logic              act_slow,
    output logic [CNT_W-1:0]  act_per,
    output logic [CNT_W-1:0]  cnt,
    output logic              raw
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             slow;
    } core_t;

    core_t            st_d, st_q;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  eff_per, eff_duty;
    logic              wrap;

    assign code     = ctrl[CODE_W-1:0];
    assign eff_per  = CNT_W'(period << code_shift(code));
    assign eff_duty = CNT_W'(duty << code_shift(code));
    assign wrap     = (st_q.per == '0) || (st_q.cnt >= st_q.per - 1'b1);

    always_comb begin
        st_d = st_q;
        if (!en || (tick && wrap)) begin
            st_d.cnt  = '0;
            st_d.per  = eff_per;
            st_d.duty = eff_duty;
            st_d.slow = (code == CODE_DIV);
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw      = en && (st_q.per != '0) && (st_q.cnt < st_q.duty);
    assign act_slow = st_q.slow;
    assign act_per  = st_q.per;
    assign cnt      = st_q.cnt;

endmodule

// File: rtl/pwm_shiftscale.sv
module pwm_shiftscale
    import pwm_ss_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int DIV_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);

    logic              en_w, tick_w, slow_w, raw_w, inv_w;
    logic [CTRL_W-1:0] ctrl_w;
    logic [CNT_W-1:0]  duty_w, period_w, act_per_w, cnt_w;

    pwm_ss_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .en(en_w), .ctrl(ctrl_w), .duty(duty_w), .period(period_w)
    );

    pwm_ss_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_w), .slow(slow_w), .tick(tick_w)
    );

    pwm_ss_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .ctrl(ctrl_w),
        .duty(duty_w), .period(period_w), .act_slow(slow_w), .act_per(act_per_w),
        .cnt(cnt_w), .raw(raw_w)
    );

    assign inv_w   = ctrl_w[INV_BIT];
    assign pwm_out = raw_w ^ inv_w;

endmodule

// File: rtl/pwm_ss_checker.sv
module pwm_ss_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             inv,
    input logic             slow,
    input logic             tick,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] cnt,
    input logic             pwm_out
);

    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> pwm_out == inv);

    a_r4_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);

    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_per != '0) |-> cnt < act_per);

    a_r9_no_midperiod_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && cnt != '0) |-> $stable(act_per));

    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slow && !tick) |=> (!en || $stable(cnt)));

    a_r10_zero_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_per == '0) |-> pwm_out == inv);

endmodule

bind pwm_shiftscale pwm_ss_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .inv(inv_w), .slow(slow_w),
    .tick(tick_w), .act_per(act_per_w), .cnt(cnt_w), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_shiftscale.sv
module tb_pwm_shiftscale;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [4:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    string req = "R1";

    always #2 clk = ~clk;

    pwm_shiftscale dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    // behavioural reference model
    int m_en, m_ctrl, m_duty, m_tcnt;
    int a_per, a_duty, a_slow, m_cnt, m_div;

    function automatic int shamt(input int c);
        case (c)
            1: return 2; 2: return 3; 3: return 4;
            4: return 6; 5: return 8; 6: return 10;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ctrl = 0; m_duty = 0; m_tcnt = 0;
            a_per = 0; a_duty = 0; a_slow = 0; m_cnt = 0; m_div = 0;
        end else begin
            bit tk, ld;
            int c;
            c  = m_ctrl & 7;
            tk = (a_slow == 0) || (m_div == 4095);
            ld = (m_en == 0) || (tk && (a_per == 0 || m_cnt >= a_per - 1));
            m_div = (m_en == 0 || a_slow == 0) ? 0 : (m_div + 1) % 4096;
            if (ld) begin
                m_cnt  = 0;
                a_per  = (m_tcnt << shamt(c)) & 16'hFFFF;
                a_duty = (m_duty << shamt(c)) & 16'hFFFF;
                a_slow = (c == 7) ? 1 : 0;
            end else if (tk) begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en && addr[4] == 0 && addr[1:0] == 0) begin
                case (addr[3:2])
                    2'd0: m_en   = int'(wdata[0]);
                    2'd1: m_ctrl = int'(wdata[3:0]);
                    2'd2: m_duty = int'(wdata[15:0]);
                    default: m_tcnt = int'(wdata[15:0]);
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_o;
            exp_o = ((m_en != 0 && a_per != 0 && m_cnt < a_duty) ? 1'b1 : 1'b0)
                    ^ m_ctrl[3];
            n_cmp++;
            if (pwm_out !== exp_o) begin
                n_bad++;
                $display("FAIL %s pwm_out actual=%b expected=%b", req, pwm_out, exp_o);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp_v, input string r);
        @(negedge clk);
        addr = a;
        #1;
        n_cmp++;
        if (rdata !== exp_v) begin
            n_bad++;
            $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", r, a, rdata, exp_v);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        req = "R1";
        for (int i = 0; i < 4; i++) rd_chk(5'(i * 4), 0, "R1");
        n_cmp++;
        if (pwm_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 pwm_out actual=%b expected=0", pwm_out);
        end
        // R2 map and masking
        req = "R2";
        wr(5'h04, 32'hFFFF_FFF0);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hABCD_1234);
        rd_chk(5'h04, 32'h0, "R2");
        rd_chk(5'h08, 32'h0000_FFFF, "R2");
        rd_chk(5'h0C, 32'h0000_1234, "R2");
        wr(5'h04, 32'h0000_000D);
        rd_chk(5'h04, 32'h0000_000D, "R2");
        wr(5'h00, 32'hFFFF_FFFE);
        rd_chk(5'h00, 32'h0, "R2");
        // R3 unmapped writes ignored
        req = "R3";
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h01, 32'h1);
        wr(5'h0E, 32'h0);
        wr(5'h1C, 32'h7777);
        rd_chk(5'h00, 32'h0, "R3");
        rd_chk(5'h04, 32'h0000_000D, "R3");
        rd_chk(5'h08, 32'h0000_FFFF, "R3");
        rd_chk(5'h0C, 32'h0000_1234, "R3");
        rd_chk(5'h10, 32'h0, "R3");
        rd_chk(5'h09, 32'h0, "R3");
        // R4 disabled with invert set: idle high
        req = "R4";
        run(20);
        // R5 code 0
        req = "R5";
        wr(5'h04, 32'h0);
        wr(5'h0C, 32'd10);
        wr(5'h08, 32'd3);
        wr(5'h00, 32'h1);
        run(45);
        // R9 change duty and period mid-period
        req = "R9";
        run(4);
        wr(5'h08, 32'd7);
        wr(5'h0C, 32'd12);
        run(40);
        // R8 invert while running
        req = "R8";
        wr(5'h04, 32'h8);
        run(30);
        wr(5'h04, 32'h0);
        // R6 shifting codes with truncation
        req = "R6";
        wr(5'h0C, 32'h4005);
        wr(5'h08, 32'h4002);
        for (int c = 1; c <= 6; c++) begin
            wr(5'h04, 32'(c));
            run(2 * (5 << shamt(c)) + 30);
        end
        rd_chk(5'h0C, 32'h4005, "R6");
        // R7 true divider
        req = "R7";
        wr(5'h0C, 32'd3);
        wr(5'h08, 32'd1);
        wr(5'h04, 32'h7);
        run(3 * 4096 * 3 + 500);
        // R10 zero period then duty above period
        req = "R10";
        wr(5'h04, 32'h0);
        wr(5'h0C, 32'd0);
        wr(5'h08, 32'd5);
        run(20000);
        wr(5'h0C, 32'd4);
        wr(5'h08, 32'd9);
        run(40);
        // R4 disable during run
        req = "R4";
        wr(5'h00, 32'h0);
        run(20);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule